// File: doc/BRIEF.md
# Privileged Trap Vector Sequencer

This block decides where a processor goes when it takes an exception and where it comes back to afterwards. Each cycle it looks at the current program counter, a 5-bit event code and a return request. When an event is taken it emits a registered redirect: a new PC, formed as the privileged base address plus a per-event offset, and the PC that follows it. It also captures the restart address in an exception-address register and controls the flag that swaps in the shadow integer registers. A return request loads the redirect target from that register. Bit 0 of that register then decides whether execution leaves privileged mode and the shadow registers are released.

Bit 0 of a PC marks privileged mode. Every vector offset is odd, so every redirect lands in privileged mode. The redirect is a one-cycle pulse on `redirect_valid` and has no ready signal. The fetch logic that consumes it must take every pulse in the cycle it appears, because the block cannot hold a redirect back. A register index input returns, combinationally, whether that register is currently routed to the shadow copy.

Top module: `trap_vector_seq`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `redirect_valid`=0, `exc_addr`=0 and `shadow_sel`=1. On the first clock edge after release, `redirect_valid` pulses for one cycle with `next_pc` = `pal_base`+0x0001 and `next_npc` = `next_pc`+4.
- R2: Event codes and offsets from `pal_base`: 1 machine check 0x0401, 2 arithmetic 0x0501, 3 interrupt 0x0101, 4 native data-translation miss 0x0201, 5 privileged data-translation miss 0x0281, 6 alignment 0x0301, 7 data fault 0x0381, 8 data access violation 0x0381, 9 instruction-translation miss 0x0181, 10 instruction fault 0x0181, 11 instruction access violation 0x0081, 12 unimplemented opcode 0x0481, 13 FP disabled 0x0581, 14 privileged call 0x2001. An event sampled at a clock edge gives, after that edge, `redirect_valid`=1, `next_pc`=`pal_base`+offset and `next_npc`=`next_pc`+4.
- R3: Code 15 (integer overflow) uses the arithmetic offset 0x0501 and saves the faulting PC unchanged.
- R4: A taken event saves `cur_pc`+4 in `exc_addr` for codes 2 and 14, and `cur_pc` for every other code.
- R5: Code 3 taken while `cur_pc[0]`=1 leaves `exc_addr` unchanged.
- R6: A taken event with `cur_pc[0]`=0 sets `shadow_sel`. With `cur_pc[0]`=1 it leaves `shadow_sel` unchanged.
- R7: `ret_req`=1 with code 0 and `cur_pc[0]`=1 gives `next_pc`=`exc_addr` and `next_npc`=`exc_addr`+4, and leaves `exc_addr` unchanged. `shadow_sel` clears if `exc_addr[0]`=0 and is otherwise unchanged.
- R8: `ret_req`=1 with code 0 and `cur_pc[0]`=0 is handled exactly as code 12.
- R9: Code 0 without a return request, or any code from 16 to 31, produces no redirect and leaves `exc_addr` and `shadow_sel` unchanged. A nonzero code takes precedence over `ret_req` in the same cycle.
- R10: `shadow_hit` = `shadow_sel` AND (`reg_idx` is 8..14 or 25), combinationally.
- R11: Events and return requests presented in the cycle of the reset redirect are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_base | input | PC_W | Privileged base address |
| cur_pc | input | PC_W | PC of the excepting or returning instruction |
| fault_code | input | 5 | Event code, 0 = none |
| ret_req | input | 1 | Return-from-privileged request |
| reg_idx | input | 5 | Integer register index to classify |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| next_pc | output | PC_W | Redirect target |
| next_npc | output | PC_W | Target plus 4 |
| exc_addr | output | PC_W | Saved restart address |
| shadow_sel | output | 1 | Shadow bank selected |
| shadow_hit | output | 1 | `reg_idx` maps to the shadow bank |

## Verification
The two pieces of state, `exc_addr` and `shadow_sel`, are both outputs. A wrong update therefore shows at the ports in the cycle right after the edge that caused it. A restart address that is off by the skip amount, or that was overwritten by a nested interrupt, also shows one cycle after the next return, as a wrong `next_pc`. A flag left set or cleared in error shows at once on `shadow_hit` for any shadowed index. It also shows as a wrong outcome on the next entry from an even PC or the next return.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int CODE_W = 5;
  localparam int OFF_W  = 14;

  localparam logic [CODE_W-1:0] EV_NONE    = 5'd0;
  localparam logic [CODE_W-1:0] EV_MCHK    = 5'd1;
  localparam logic [CODE_W-1:0] EV_ARITH   = 5'd2;
  localparam logic [CODE_W-1:0] EV_INTR    = 5'd3;
  localparam logic [CODE_W-1:0] EV_DMISS_N = 5'd4;
  localparam logic [CODE_W-1:0] EV_DMISS_P = 5'd5;
  localparam logic [CODE_W-1:0] EV_ALIGN   = 5'd6;
  localparam logic [CODE_W-1:0] EV_DFAULT  = 5'd7;
  localparam logic [CODE_W-1:0] EV_DACV    = 5'd8;
  localparam logic [CODE_W-1:0] EV_IMISS   = 5'd9;
  localparam logic [CODE_W-1:0] EV_IFAULT  = 5'd10;
  localparam logic [CODE_W-1:0] EV_IACV    = 5'd11;
  localparam logic [CODE_W-1:0] EV_OPDEC   = 5'd12;
  localparam logic [CODE_W-1:0] EV_FPDIS   = 5'd13;
  localparam logic [CODE_W-1:0] EV_PCALL   = 5'd14;
  localparam logic [CODE_W-1:0] EV_OVF     = 5'd15;

  localparam logic [OFF_W-1:0] BOOT_OFF = 14'h0001;

  typedef struct packed {
    logic             known;
    logic             skip;
    logic [OFF_W-1:0] off;
  } vec_info_t;
endpackage

// File: rtl/tvs_vector_lut.sv
module tvs_vector_lut
  import tvs_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output vec_info_t         info
);
  always_comb begin
    info.known = 1'b1;
    info.skip  = 1'b0;
    info.off   = '0;
    unique case (code)
      EV_MCHK:             info.off = 14'h0401;
      EV_ARITH: begin      info.off = 14'h0501; info.skip = 1'b1; end
      EV_INTR:             info.off = 14'h0101;
      EV_DMISS_N:          info.off = 14'h0201;
      EV_DMISS_P:          info.off = 14'h0281;
      EV_ALIGN:            info.off = 14'h0301;
      EV_DFAULT, EV_DACV:  info.off = 14'h0381;
      EV_IMISS, EV_IFAULT: info.off = 14'h0181;
      EV_IACV:             info.off = 14'h0081;
      EV_OPDEC:            info.off = 14'h0481;
      EV_FPDIS:            info.off = 14'h0581;
      EV_PCALL: begin      info.off = 14'h2001; info.skip = 1'b1; end
      EV_OVF:              info.off = 14'h0501;
      default:             info.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/tvs_shadow_map.sv
module tvs_shadow_map #(
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic [NREGS-1:0] mask;

  for (genvar g = 0; g < NREGS; g++) begin : g_mask
    assign mask[g] = ((g >= 8) && (g <= 14)) || (g == 25);
  end

  assign hit = sel & mask[idx];
endmodule

// File: rtl/trap_vector_seq.sv
module trap_vector_seq
  import tvs_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pal_base,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [CODE_W-1:0] fault_code,
  input  logic              ret_req,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   next_npc,
  output logic [PC_W-1:0]   exc_addr,
  output logic              shadow_sel,
  output logic              shadow_hit
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic              boot_pend;
  logic              in_priv;
  logic [CODE_W-1:0] eff_code;
  vec_info_t         vinfo;
  logic              take_fault;
  logic              take_ret;
  logic              keep_exc;
  logic [PC_W-1:0]   vec_pc;
  logic [PC_W-1:0]   save_pc;

  assign in_priv  = cur_pc[0];
  assign eff_code = (fault_code != EV_NONE) ? fault_code :
                    (ret_req && !in_priv) ? EV_OPDEC : EV_NONE;

  tvs_vector_lut u_lut (.code(eff_code), .info(vinfo));

  assign take_fault = !boot_pend && vinfo.known;
  assign take_ret   = !boot_pend && (fault_code == EV_NONE) && ret_req && in_priv;
  assign keep_exc   = (eff_code == EV_INTR) && in_priv;
  assign vec_pc     = pal_base + PC_W'(vinfo.off);
  assign save_pc    = vinfo.skip ? (cur_pc + STEP) : cur_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend      <= 1'b1;
      redirect_valid <= 1'b0;
      next_pc        <= '0;
      next_npc       <= '0;
      exc_addr       <= '0;
      shadow_sel     <= 1'b1;
    end else if (boot_pend) begin
      boot_pend      <= 1'b0;
      redirect_valid <= 1'b1;
      next_pc        <= pal_base + PC_W'(BOOT_OFF);
      next_npc       <= pal_base + PC_W'(BOOT_OFF) + STEP;
    end else begin
      redirect_valid <= take_fault || take_ret;
      if (take_fault) begin
        next_pc  <= vec_pc;
        next_npc <= vec_pc + STEP;
        if (!keep_exc) exc_addr <= save_pc;
        if (!in_priv) shadow_sel <= 1'b1;
      end else if (take_ret) begin
        next_pc  <= exc_addr;
        next_npc <= exc_addr + STEP;
        if (!exc_addr[0]) shadow_sel <= 1'b0;
      end
    end
  end

  tvs_shadow_map #(.NREGS(NREGS), .IDX_W(IDX_W)) u_map (
    .sel(shadow_sel), .idx(reg_idx), .hit(shadow_hit)
  );

  assert_boot_redirect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pend |=> redirect_valid && (next_pc == $past(pal_base) + PC_W'(BOOT_OFF)));

  assert_npc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (next_npc == next_pc + STEP));

  assert_intr_keeps_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_pend && fault_code == EV_INTR && cur_pc[0]) |=> $stable(exc_addr));

  assert_entry_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fault && !cur_pc[0]) |=> shadow_sel);

  assert_ret_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> (next_pc == $past(exc_addr)) && $stable(exc_addr));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_pend && fault_code == EV_NONE && !ret_req) |=>
      !redirect_valid && $stable(exc_addr) && $stable(shadow_sel));

  assert_hit_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_hit |-> shadow_sel);
endmodule

// File: tb/trap_vector_seq_test.sv
`timescale 1ns/1ps
module trap_vector_seq_test;
  localparam int PC_W = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] pal_base = '0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [4:0]      fault_code = '0;
  logic            ret_req = 1'b0;
  logic [4:0]      reg_idx = '0;
  logic            redirect_valid;
  logic [PC_W-1:0] next_pc, next_npc, exc_addr;
  logic            shadow_sel, shadow_hit;

  int n_cmp = 0;
  int n_bad = 0;
  logic [PC_W-1:0] m_exc;
  logic            m_sh;

  always #2.5 clk = ~clk;

  trap_vector_seq uut (
    .clk(clk), .rst_n(rst_n), .pal_base(pal_base), .cur_pc(cur_pc),
    .fault_code(fault_code), .ret_req(ret_req), .reg_idx(reg_idx),
    .redirect_valid(redirect_valid), .next_pc(next_pc), .next_npc(next_npc),
    .exc_addr(exc_addr), .shadow_sel(shadow_sel), .shadow_hit(shadow_hit)
  );

  function automatic logic [PC_W-1:0] ref_off(input logic [4:0] c);
    case (c)
      5'd1: return 64'h401;   5'd2: return 64'h501;   5'd3: return 64'h101;
      5'd4: return 64'h201;   5'd5: return 64'h281;   5'd6: return 64'h301;
      5'd7: return 64'h381;   5'd8: return 64'h381;   5'd9: return 64'h181;
      5'd10: return 64'h181;  5'd11: return 64'h081;  5'd12: return 64'h481;
      5'd13: return 64'h581;  5'd14: return 64'h2001; 5'd15: return 64'h501;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic ref_shadowed(input logic [4:0] i);
    return ((i >= 5'd8) && (i <= 5'd14)) || (i == 5'd25);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] pc, input logic [4:0] code,
                      input logic r, input logic [PC_W-1:0] base,
                      input logic [4:0] idx);
    logic [4:0] eff;
    logic known, is_ret, ev;
    logic [PC_W-1:0] exp_pc;
    string tp, te, ts;
    @(negedge clk);
    cur_pc = pc; fault_code = code; ret_req = r; pal_base = base; reg_idx = idx;
    @(posedge clk);
    #1;
    eff = code;
    if (code == 5'd0 && r && !pc[0]) eff = 5'd12;
    known  = (eff != 5'd0) && (eff < 5'd16);
    is_ret = (code == 5'd0) && r && pc[0];
    exp_pc = '0;
    tp = (code == 5'd0 && r) ? (pc[0] ? "R7" : "R8") : "R2";
    te = (eff == 5'd3 && pc[0]) ? "R5" : ((eff == 5'd15) ? "R3" : "R4");
    ts = is_ret ? "R7" : "R6";
    ev = known || is_ret;
    if (known) begin
      exp_pc = base + ref_off(eff);
      if (!(eff == 5'd3 && pc[0]))
        m_exc = pc + (((eff == 5'd2) || (eff == 5'd14)) ? 64'd4 : 64'd0);
      if (!pc[0]) m_sh = 1'b1;
    end else if (is_ret) begin
      exp_pc = m_exc;
      if (!m_exc[0]) m_sh = 1'b0;
    end
    if (!ev) begin te = "R9"; ts = "R9"; end
    chk(ev ? tp : "R9", "redirect_valid", 64'(redirect_valid), 64'(ev));
    if (ev) begin
      chk(tp, "next_pc", next_pc, exp_pc);
      chk("R2", "next_npc", next_npc, exp_pc + 64'd4);
    end
    chk(te, "exc_addr", exc_addr, m_exc);
    chk(ts, "shadow_sel", 64'(shadow_sel), 64'(m_sh));
    chk("R10", "shadow_hit", 64'(shadow_hit), 64'(m_sh && ref_shadowed(idx)));
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] b;
    b = 64'h0000_0000_0010_0000;
    void'($urandom(32'd1234));
    pal_base = b;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "redirect_valid", 64'(redirect_valid), 64'd0);
    chk("R1", "exc_addr", exc_addr, 64'd0);
    chk("R1", "shadow_sel", 64'(shadow_sel), 64'd1);
    // R11: an event offered in the boot cycle is dropped
    @(negedge clk);
    rst_n = 1'b1; fault_code = 5'd1; cur_pc = 64'h5000;
    @(posedge clk);
    #1;
    chk("R1", "boot next_pc", next_pc, b + 64'h1);
    chk("R1", "boot next_npc", next_npc, b + 64'h5);
    chk("R1", "boot valid", 64'(redirect_valid), 64'd1);
    chk("R11", "exc_addr", exc_addr, 64'd0);
    m_exc = '0; m_sh = 1'b1;

    // R2, R3, R4 each code from a non-privileged PC
    for (int c = 1; c < 16; c++) step(64'h1000 + 64'(c * 16), 5'(c), 1'b0, b, 5'(c));
    // R7 return to even address clears shadow
    step(64'h2000, 5'd6, 1'b0, b, 5'd9);
    step(b + 64'h301, 5'd0, 1'b1, b, 5'd9);
    // R6 entry while privileged keeps the flag clear
    step(b + 64'h101, 5'd7, 1'b0, b, 5'd25);
    // R7 return to odd address keeps the flag set
    step(64'h3000, 5'd4, 1'b0, b, 5'd8);
    step(b + 64'h201, 5'd9, 1'b0, b, 5'd8);
    step(b + 64'h181, 5'd0, 1'b1, b, 5'd14);
    // R5 nested interrupt leaves exc_addr alone
    step(b + 64'h381, 5'd3, 1'b0, b, 5'd0);
    // R8 return from user mode
    step(64'h4440, 5'd0, 1'b1, b, 5'd10);
    // R9 undefined codes, idle, precedence over return
    step(64'h4444, 5'd20, 1'b0, b, 5'd11);
    step(b + 64'h81, 5'd31, 1'b1, b, 5'd11);
    step(64'h4448, 5'd0, 1'b0, b, 5'd12);
    step(b + 64'h81, 5'd14, 1'b1, b, 5'd13);

    for (int k = 0; k < 4000; k++) begin
      logic [PC_W-1:0] pc;
      logic [4:0] code;
      pc = {32'($urandom), 32'($urandom)};
      code = 5'($urandom % 20);
      if ($urandom % 3 == 0) code = 5'd0;
      if (k % 64 == 0) b = {32'($urandom), 32'($urandom)} & ~64'hFFFF;
      step(pc, code, ($urandom % 4) == 0, b, 5'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule